// File: doc/BRIEF.md
# Extended-Carry Integer ALU

This unit is the arithmetic and logic stage of a small embedded CPU core. Each beat carries a destination operand, a source operand, an operation code, an operand size (byte, word or dword) and three condition-code bits from the core's flag register: carry C (bit 0 of that register), extend X (bit 4) and R (bit 8). The unit returns one registered result beat. That beat holds the value to write back, a writeback enable, the N/Z/V/C flags, and for multiplies the upper product word with a strobe for the multiply-overflow register.

The carry chain is "extended". Plain add, subtract, compare and negate fold in the previous carry only while X is set, so multi-word arithmetic can be chained without separate opcodes. Shift amounts of 32 or more saturate instead of wrapping. Byte and word operations change only the low bits of the destination and leave its upper bits as they were.

Both edges use valid/ready. A beat is taken when `in_valid` and `in_ready` are both high. Its result is presented one cycle later with `out_valid`. While `out_valid` is high and `out_ready` is low, the result is held unchanged and `in_ready` is low, so back-pressure passes straight upstream with no extra buffering.

Top module: `xc_alu`

## Requirements
- R1: `in_ready` is high when `out_valid` is low or `out_ready` is high. An accepted beat gives `out_valid` high on the next cycle. While `out_valid && !out_ready`, every output is held stable. After reset `out_valid` is 0.
- R2: ADD (op 0) gives dst + src + (X AND C). When X is 0, C has no effect.
- R3: ADDC (op 1) gives dst + src + C whatever X is. ADDR (op 2) gives dst + src + R and ignores C and X.
- R4: SUB (op 3) gives dst − src − (X AND C). NEG (op 5) gives 0 − src − (X AND C).
- R5: CMP (op 4) produces the same flags and value as SUB, with `out_wb` = 0. Every other op has `out_wb` = 1.
- R6: MOVE (op 6) gives src. BOUND (op 10) gives dst when dst ≤ src (unsigned) and src otherwise.
- R7: LSL (op 7) and LSR (op 8) shift dst by the unsigned src amount. Any amount above 31 gives 0.
- R8: ASR (op 9) shifts dst arithmetically for amounts 0..31. For larger amounts it gives 0 when the amount is below 0x80000000 and all ones otherwise.
- R9: MULS (op 11, signed) and MULU (op 12, unsigned) form the 64-bit product. The low word is the result, the high word appears on `out_mof`, and `out_mof_we` = 1. Every other op drives `out_mof` = 0 and `out_mof_we` = 0.
- R10: Size code 0 is byte (8 bits), 1 is word (16 bits), and 2 or 3 is dword. The result's low size bits come from the operation and its upper bits from dst.
- R11: `out_flags` = {N, Z, V, C} (bit 3 down to 0). N is the top bit of the size-masked result. Z is set when the size-masked result is zero.
- R12: For ADD/ADDC/ADDR, C is the carry out of the selected width and V is signed overflow. For SUB/CMP/NEG, C is the borrow out of that width and V is signed overflow of the subtraction. All other ops give C = V = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation beat offered |
| in_ready | output | 1 | Unit can take a beat |
| in_op | input | 4 | Operation code (R2–R9) |
| in_size | input | 2 | Operand size code (R10) |
| in_dst | input | DATA_W | Destination operand |
| in_src | input | DATA_W | Source operand or shift amount |
| in_c | input | 1 | Carry flag, register bit 0 |
| in_x | input | 1 | Extend flag, register bit 4 |
| in_r | input | 1 | R flag, register bit 8 |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | DATA_W | Writeback value (size-merged) |
| out_mof | output | DATA_W | Upper product word |
| out_mof_we | output | 1 | Write strobe for the multiply-overflow register |
| out_wb | output | 1 | Register writeback enable |
| out_flags | output | 4 | {N, Z, V, C} |

## Verification
The assertions assume a clean reset and that the operation fields are known whenever `in_valid` is high. The shift-saturation check applies only to dword-size beats, because at smaller sizes the upper bits come from dst. The bench offers one beat at a time and drops `in_valid` between beats. It uses only the thirteen defined op codes and size codes 0 to 2, and mixes random operands with shift amounts of 31, 32 and 0x80000000. Back-pressure is exercised by holding `out_ready` low over several cycles while a result is pending.

// File: rtl/xc_alu_pkg.sv
package xc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDC  = 4'd1,
    OP_ADDR  = 4'd2,
    OP_SUB   = 4'd3,
    OP_CMP   = 4'd4,
    OP_NEG   = 4'd5,
    OP_MOVE  = 4'd6,
    OP_LSL   = 4'd7,
    OP_LSR   = 4'd8,
    OP_ASR   = 4'd9,
    OP_BOUND = 4'd10,
    OP_MULS  = 4'd11,
    OP_MULU  = 4'd12
  } op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_ARITH = 2'd2
  } shift_e;

  localparam int N_WIDTHS = 3;
  localparam int FLAG_C = 0;
  localparam int FLAG_V = 1;
  localparam int FLAG_Z = 2;
  localparam int FLAG_N = 3;
endpackage

// File: rtl/xc_alu_arith.sv
module xc_alu_arith #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic [2:0]        carry_w,
  output logic [2:0]        ovf_w
);
  assign sum = sub ? (a - b - {{(DATA_W-1){1'b0}}, cin})
                   : (a + b + {{(DATA_W-1){1'b0}}, cin});

  for (genvar g = 0; g < 3; g++) begin : g_width
    localparam int W = (g == 0) ? 8 : (g == 1) ? 16 : DATA_W;
    logic [W:0] ext;
    assign ext = sub ? ({1'b0, a[W-1:0]} - {1'b0, b[W-1:0]} - {{W{1'b0}}, cin})
                     : ({1'b0, a[W-1:0]} + {1'b0, b[W-1:0]} + {{W{1'b0}}, cin});
    assign carry_w[g] = ext[W];
    assign ovf_w[g]   = sub ? ((a[W-1] != b[W-1]) && (ext[W-1] != a[W-1]))
                            : ((a[W-1] == b[W-1]) && (ext[W-1] != a[W-1]));
  end
endmodule

// File: rtl/xc_alu_shift.sv
module xc_alu_shift
  import xc_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] val,
  input  logic [DATA_W-1:0] amt,
  input  shift_e            kind,
  output logic [DATA_W-1:0] res
);
  localparam int SH_W = $clog2(DATA_W);

  logic big;
  logic [SH_W-1:0] n;
  assign big = |amt[DATA_W-1:SH_W];
  assign n   = amt[SH_W-1:0];

  always_comb begin
    unique case (kind)
      SH_LEFT:  res = big ? '0 : (val << n);
      SH_RIGHT: res = big ? '0 : (val >> n);
      default:  res = big ? {DATA_W{amt[DATA_W-1]}}
                          : DATA_W'($signed(val) >>> n);
    endcase
  end
endmodule

// File: rtl/xc_alu_mul.sv
module xc_alu_mul #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              signed_mode,
  output logic [DATA_W-1:0] lo,
  output logic [DATA_W-1:0] hi
);
  localparam int P_W = 2 * DATA_W;

  logic [P_W-1:0] ext_a, ext_b, prod;
  assign ext_a = {{DATA_W{signed_mode & a[DATA_W-1]}}, a};
  assign ext_b = {{DATA_W{signed_mode & b[DATA_W-1]}}, b};
  assign prod  = ext_a * ext_b;
  assign lo    = prod[DATA_W-1:0];
  assign hi    = prod[P_W-1:DATA_W];
endmodule

// File: rtl/xc_alu.sv
module xc_alu
  import xc_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [1:0]        in_size,
  input  logic [DATA_W-1:0] in_dst,
  input  logic [DATA_W-1:0] in_src,
  input  logic              in_c,
  input  logic              in_x,
  input  logic              in_r,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [DATA_W-1:0] out_mof,
  output logic              out_mof_we,
  output logic              out_wb,
  output logic [3:0]        out_flags
);
  op_e op;
  assign op = op_e'(in_op);

  // operand steering
  logic is_add, is_sub, cin;
  logic [DATA_W-1:0] arith_a;
  assign is_add  = (op == OP_ADD) || (op == OP_ADDC) || (op == OP_ADDR);
  assign is_sub  = (op == OP_SUB) || (op == OP_CMP) || (op == OP_NEG);
  assign arith_a = (op == OP_NEG) ? '0 : in_dst;

  always_comb begin
    unique case (op)
      OP_ADDC: cin = in_c;
      OP_ADDR: cin = in_r;
      default: cin = in_x & in_c;
    endcase
  end

  logic [DATA_W-1:0] sum;
  logic [2:0] carry_w, ovf_w;
  xc_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a(arith_a), .b(in_src), .cin(cin), .sub(is_sub),
    .sum(sum), .carry_w(carry_w), .ovf_w(ovf_w)
  );

  shift_e sh_kind;
  logic [DATA_W-1:0] sh_res;
  assign sh_kind = (op == OP_LSL) ? SH_LEFT : (op == OP_LSR) ? SH_RIGHT : SH_ARITH;
  xc_alu_shift #(.DATA_W(DATA_W)) u_shift (
    .val(in_dst), .amt(in_src), .kind(sh_kind), .res(sh_res)
  );

  logic [DATA_W-1:0] mul_lo, mul_hi;
  logic is_mul;
  assign is_mul = (op == OP_MULS) || (op == OP_MULU);
  xc_alu_mul #(.DATA_W(DATA_W)) u_mul (
    .a(in_dst), .b(in_src), .signed_mode(op == OP_MULS),
    .lo(mul_lo), .hi(mul_hi)
  );

  // result select
  logic [DATA_W-1:0] raw;
  always_comb begin
    unique case (op)
      OP_MOVE:          raw = in_src;
      OP_LSL, OP_LSR,
      OP_ASR:           raw = sh_res;
      OP_BOUND:         raw = (in_dst <= in_src) ? in_dst : in_src;
      OP_MULS, OP_MULU: raw = mul_lo;
      default:          raw = sum;
    endcase
  end

  // size handling
  logic [1:0] sz;
  logic [DATA_W-1:0] mask, sized, merged;
  logic sign_bit;
  assign sz = (in_size == 2'd3) ? 2'd2 : in_size;
  always_comb begin
    unique case (sz)
      2'd0:    begin mask = DATA_W'(8'hFF);    sign_bit = raw[7];  end
      2'd1:    begin mask = DATA_W'(16'hFFFF); sign_bit = raw[15]; end
      default: begin mask = '1;                sign_bit = raw[DATA_W-1]; end
    endcase
  end
  assign sized  = raw & mask;
  assign merged = (in_dst & ~mask) | sized;

  logic [3:0] flags_d;
  always_comb begin
    flags_d         = '0;
    flags_d[FLAG_N] = sign_bit;
    flags_d[FLAG_Z] = (sized == '0);
    if (is_add || is_sub) begin
      flags_d[FLAG_C] = carry_w[sz];
      flags_d[FLAG_V] = ovf_w[sz];
    end
  end

  // output stage
  logic fire;
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_mof    <= '0;
      out_mof_we <= 1'b0;
      out_wb     <= 1'b0;
      out_flags  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (fire) begin
        out_result <= merged;
        out_mof    <= is_mul ? mul_hi : '0;
        out_mof_we <= is_mul;
        out_wb     <= (op != OP_CMP);
        out_flags  <= flags_d;
      end
    end
  end
endmodule

// File: rtl/xc_alu_checker.sv
module xc_alu_checker
  import xc_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [3:0]        in_op,
  input logic [1:0]        in_size,
  input logic [DATA_W-1:0] in_src,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic [DATA_W-1:0] out_mof,
  input logic              out_mof_we,
  input logic              out_wb,
  input logic [3:0]        out_flags
);
  logic fire;
  assign fire = in_valid && in_ready;

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
                                   && $stable(out_flags) && $stable(out_mof)));

  assert_cmp_nowb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == OP_CMP) |=> !out_wb);

  assert_mof_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op != OP_MULS && in_op != OP_MULU) |=> (!out_mof_we && out_mof == '0));

  assert_lsl_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == OP_LSL && in_size == 2'd2 && in_src > DATA_W'(DATA_W-1))
      |=> (out_result == '0 && out_flags[FLAG_Z]));

  assert_nz_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_flags[FLAG_Z] && out_flags[FLAG_N]));

  assert_move_cv_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == OP_MOVE) |=> (out_flags[FLAG_C] == 1'b0 && out_flags[FLAG_V] == 1'b0));
endmodule

bind xc_alu xc_alu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_size(in_size), .in_src(in_src),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_mof(out_mof), .out_mof_we(out_mof_we), .out_wb(out_wb), .out_flags(out_flags)
);

// File: tb/test_xc_alu.sv
`timescale 1ns/1ps
module test_xc_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [3:0] in_op = '0;
  logic [1:0] in_size = '0;
  logic [31:0] in_dst = '0, in_src = '0;
  logic in_c = 1'b0, in_x = 1'b0, in_r = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [31:0] out_result, out_mof;
  logic out_mof_we, out_wb;
  logic [3:0] out_flags;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  xc_alu #(.DATA_W(32)) i_xc_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .in_dst(in_dst), .in_src(in_src),
    .in_c(in_c), .in_x(in_x), .in_r(in_r), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_mof(out_mof),
    .out_mof_we(out_mof_we), .out_wb(out_wb), .out_flags(out_flags)
  );

  // {op4, size2, dst32, src32, ccs16 (C=b0 X=b4 R=b8), res32, mof32, flags4 NZVC, wb1}
  localparam int NV = 23;
  localparam logic [154:0] VEC [NV] = '{
    {4'd0, 2'd2, 32'h1,        32'h2,        16'h011, 32'h4,        32'h0, 4'h0, 1'b1}, // R2 X&C
    {4'd0, 2'd2, 32'h1,        32'h2,        16'h001, 32'h3,        32'h0, 4'h0, 1'b1}, // R2 X clear
    {4'd0, 2'd2, 32'hFFFFFFFF, 32'h1,        16'h000, 32'h0,        32'h0, 4'h5, 1'b1}, // R12 carry
    {4'd1, 2'd2, 32'h5,        32'h6,        16'h001, 32'hC,        32'h0, 4'h0, 1'b1}, // R3 addc
    {4'd2, 2'd2, 32'h5,        32'h6,        16'h101, 32'hC,        32'h0, 4'h0, 1'b1}, // R3 addr
    {4'd3, 2'd2, 32'h5,        32'h3,        16'h011, 32'h1,        32'h0, 4'h0, 1'b1}, // R4 sub
    {4'd3, 2'd2, 32'h3,        32'h5,        16'h000, 32'hFFFFFFFE, 32'h0, 4'h9, 1'b1}, // R4 borrow
    {4'd4, 2'd2, 32'h7,        32'h7,        16'h000, 32'h0,        32'h0, 4'h4, 1'b0}, // R5 cmp
    {4'd5, 2'd2, 32'h0,        32'h1,        16'h011, 32'hFFFFFFFE, 32'h0, 4'h9, 1'b1}, // R4 neg
    {4'd6, 2'd0, 32'hAABBCCDD, 32'h12345678, 16'h000, 32'hAABBCC78, 32'h0, 4'h0, 1'b1}, // R10 move
    {4'd7, 2'd2, 32'h1,        32'd31,       16'h000, 32'h80000000, 32'h0, 4'h8, 1'b1}, // R7
    {4'd7, 2'd2, 32'h1,        32'd32,       16'h000, 32'h0,        32'h0, 4'h4, 1'b1}, // R7 sat
    {4'd8, 2'd2, 32'h80000000, 32'd32,       16'h000, 32'h0,        32'h0, 4'h4, 1'b1}, // R7 sat
    {4'd9, 2'd2, 32'h80000000, 32'd31,       16'h000, 32'hFFFFFFFF, 32'h0, 4'h8, 1'b1}, // R8
    {4'd9, 2'd2, 32'h80000000, 32'd32,       16'h000, 32'h0,        32'h0, 4'h4, 1'b1}, // R8 low sat
    {4'd9, 2'd2, 32'h1,        32'h80000000, 16'h000, 32'hFFFFFFFF, 32'h0, 4'h8, 1'b1}, // R8 high sat
    {4'd10,2'd2, 32'h5,        32'h9,        16'h000, 32'h5,        32'h0, 4'h0, 1'b1}, // R6 bound
    {4'd10,2'd2, 32'hA,        32'h9,        16'h000, 32'h9,        32'h0, 4'h0, 1'b1}, // R6 bound
    {4'd12,2'd2, 32'hFFFFFFFF, 32'h2,        16'h000, 32'hFFFFFFFE, 32'h1, 4'h8, 1'b1}, // R9 mulu
    {4'd11,2'd2, 32'hFFFFFFFF, 32'h2,        16'h000, 32'hFFFFFFFE, 32'hFFFFFFFF, 4'h8, 1'b1}, // R9 muls
    {4'd0, 2'd0, 32'h123456FF, 32'h1,        16'h000, 32'h12345600, 32'h0, 4'h5, 1'b1}, // R10 byte
    {4'd0, 2'd1, 32'h00007FFF, 32'h1,        16'h000, 32'h00008000, 32'h0, 4'hA, 1'b1}, // R11 word
    {4'd3, 2'd0, 32'h00000080, 32'h1,        16'h000, 32'h0000007F, 32'h0, 4'h2, 1'b1}  // R12 byte
  };

  function automatic string req_of(logic [3:0] op, logic [1:0] sz);
    if (sz != 2'd2) return "R10";
    case (op)
      4'd0: return "R2";
      4'd1, 4'd2: return "R3";
      4'd3, 4'd5: return "R4";
      4'd4: return "R5";
      4'd6, 4'd10: return "R6";
      4'd7, 4'd8: return "R7";
      4'd9: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Independent reference model
  task automatic model(input logic [3:0] op, input logic [1:0] sz,
                       input logic [31:0] d, input logic [31:0] s,
                       input logic c, input logic x, input logic r,
                       output logic [31:0] res, output logic [31:0] mof,
                       output logic [3:0] fl, output logic wb);
    int w;
    logic [63:0] m, e, p, a;
    logic [31:0] raw, sized;
    logic ci, arith, sub;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = (64'd1 << w) - 64'd1;
    ci = (op == 4'd1) ? c : (op == 4'd2) ? r : (x & c);
    arith = (op <= 4'd5);
    sub = (op >= 4'd3) && (op <= 4'd5);
    a = (op == 4'd5) ? 64'd0 : {32'd0, d};
    e = sub ? ((a & m) - ({32'd0, s} & m) - {63'd0, ci})
            : ((a & m) + ({32'd0, s} & m) + {63'd0, ci});
    mof = 32'd0;
    p = 64'd0;
    case (op)
      4'd6: raw = s;
      4'd7: raw = (s > 32'd31) ? 32'd0 : d << s[4:0];
      4'd8: raw = (s > 32'd31) ? 32'd0 : d >> s[4:0];
      4'd9: raw = (s > 32'd31) ? {32{s[31]}} : 32'($signed(d) >>> s[4:0]);
      4'd10: raw = (d <= s) ? d : s;
      4'd11: begin p = {{32{d[31]}}, d} * {{32{s[31]}}, s}; raw = p[31:0]; mof = p[63:32]; end
      4'd12: begin p = {32'd0, d} * {32'd0, s}; raw = p[31:0]; mof = p[63:32]; end
      default: raw = sub ? (a[31:0] - s - {31'd0, ci}) : (d + s + {31'd0, ci});
    endcase
    sized = raw & m[31:0];
    res = (d & ~m[31:0]) | sized;
    fl = '0;
    fl[3] = sized[w-1];
    fl[2] = (sized == 32'd0);
    if (arith) begin
      fl[0] = e[w];
      fl[1] = sub ? ((a[w-1] != s[w-1]) && (e[w-1] != a[w-1]))
                  : ((a[w-1] == s[w-1]) && (e[w-1] != a[w-1]));
    end
    wb = (op != 4'd4);
  endtask

  task automatic beat(logic [3:0] op, logic [1:0] sz, logic [31:0] d, logic [31:0] s,
                      logic c, logic x, logic r);
    @(negedge clk);
    in_op = op; in_size = sz; in_dst = d; in_src = s;
    in_c = c; in_x = x; in_r = r; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] er, em;
    logic [3:0] ef;
    logic ew;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [154:0] v;
      string t;
      v = VEC[i];
      t = req_of(v[154:151], v[150:149]);
      beat(v[154:151], v[150:149], v[148:117], v[116:85], v[69], v[73], v[77]);
      check({t, " valid"}, {31'd0, out_valid}, 32'd1);
      check({t, " result"}, out_result, v[68:37]);
      check({t, " mof"}, out_mof, v[36:5]);
      check({t, " mof_we"}, {31'd0, out_mof_we},
            {31'd0, (v[154:151] == 4'd11 || v[154:151] == 4'd12)});
      check({t, " R11 R12 flags"}, {28'd0, out_flags}, {28'd0, v[4:1]});
      check({t, " R5 wb"}, {31'd0, out_wb}, {31'd0, v[0]});
    end

    // R2 R3 R4: each carry source alone has no effect where it is ignored
    beat(4'd0, 2'd2, 32'h10, 32'h1, 1'b1, 1'b0, 1'b1);
    check("R2 C without X ignored", out_result, 32'h11);
    beat(4'd2, 2'd2, 32'h10, 32'h1, 1'b1, 1'b1, 1'b0);
    check("R3 addr ignores C", out_result, 32'h11);
    beat(4'd3, 2'd2, 32'h10, 32'h1, 1'b1, 1'b0, 1'b0);
    check("R4 C without X ignored", out_result, 32'hF);

    // R1 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    beat(4'd6, 2'd2, 32'h0, 32'hCAFEF00D, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      in_op = 4'd6; in_src = 32'h0BADBEEF; in_valid = 1'b1;
      check("R1 held valid", {31'd0, out_valid}, 32'd1);
      check("R1 stall ready", {31'd0, in_ready}, 32'd0);
      check("R1 held result", out_result, 32'hCAFEF00D);
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 drained", {31'd0, out_valid}, 32'd0);

    // random sweep against the model
    for (int n = 0; n < 400; n++) begin
      logic [3:0] op;
      logic [1:0] sz;
      logic [31:0] d, s;
      logic c, x, r;
      op = 4'($urandom_range(0, 12));
      sz = 2'($urandom_range(0, 2));
      d = $urandom;
      s = $urandom;
      case (n % 8)
        0: s = 32'd31;
        1: s = 32'd32;
        2: s = 32'h80000000;
        3: s = 32'($urandom_range(0, 40));
        default: ;
      endcase
      c = 1'($urandom); x = 1'($urandom); r = 1'($urandom);
      model(op, sz, d, s, c, x, r, er, em, ef, ew);
      beat(op, sz, d, s, c, x, r);
      check({req_of(op, sz), " rand result"}, out_result, er);
      check("R9 rand mof", out_mof, em);
      check("R11 R12 rand flags", {28'd0, out_flags}, {28'd0, ef});
      check("R5 rand wb", {31'd0, out_wb}, {31'd0, ew});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule